// File: doc/BRIEF.md
# Diversified-Input Triple-Redundant Datapath

This block evaluates a fixed combinational function of `N_IN` inputs in three replicas and votes on whole output words. The replicas do not see the same bits. Replica A stores the operand as given. Replica B stores its bitwise complement and drives an inverted result word. Replica C stores the operand rotated by one place toward the lower index. A stuck-at fault that hits the same stored position in several registers therefore corrupts different logical inputs in each replica.

Every replica extends its result with parity check bits whose form depends on whether `N_IN` is odd or even. Because of these bits, two corrupted replicas cannot agree on a wrong word. The word voter re-inverts replica B's word and compares the three words. It passes on a word that at least two replicas share, and it raises an error when all three differ.

Operands arrive on a valid/ready input and results leave on a valid/ready output, with one result slot between them. A new operand is accepted when the slot is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the slot holds its value and no input is taken. Fault-injection ports force any stored register bit to a chosen value, for use in verification.

Top module: `divtmr_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_err` are 0 and `in_ready` is 1.
- R2: An operand accepted at a clock edge (`in_valid && in_ready`) appears at the next edge with `out_valid` = 1. With bit 0 = x1, bit 1 = x2 and bit 2 = x3, `out_data[0]` = x1·x2' + x2·x3 and `out_data[1]` = x1·x2' + x2·x3'. For example, x1=1, x2=0, x3=0 gives 2'b11.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_data` stay unchanged as long as the fault controls are unchanged.
- R4: With no fault injected, `out_err` is never 1 and every operand gives the R2 result; `out_err` can be 1 only while some `flt_en` bit is set.
- R5: `flt_en[r*N_IN+i]` forces stored bit i of register r to `flt_val[r*N_IN+i]`, where r=0 is the true register, r=1 the complemented one and r=2 the rotated one. The force acts at once, without a reload.
- R6: A stuck bit in any one register, at any position and either value, leaves `out_data` correct and `out_err` at 0.
- R7: For every operand, every position and every stuck value, a fault at the same position of two or three registers yields either a correct `out_data` or `out_err` = 1.
- R8: With x1=0, x2=0, x3=1 and position 0 of all three registers stuck at 1, `out_err` is 1.
- R9: Register r=1 holds the complement of the operand and register r=2 holds it rotated, with stored position i holding input bit (i+1) mod N_IN. So, for operand 0, register 0 bit 0 stuck at 1 together with register 2 bit N_IN-1 stuck at 1 gives the wrong word 2'b11 with no error. The same happens with register 0 bit 0 stuck at 1 together with register 1 bit 0 stuck at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand slot can accept |
| in_data | input | N_IN | Operand, bit 0 = x1 |
| out_valid | output | 1 | Voted result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 2 | Voted function bits |
| out_err | output | 1 | No two replica words agree (gated by out_valid) |
| flt_en | input | 3*N_IN | Per stored bit: force enable |
| flt_val | input | 3*N_IN | Per stored bit: forced value |

## Verification
The bench sweeps every operand against every same-position fault on each pair and on all three registers, at both stuck values. A design without the check bits, or with the wrong parity selection, would show a wrong `out_data` with `out_err` low. Deliberately chosen cross-position faults expose a missing complement or a rotation in the wrong direction: a correct design must let those particular pairs agree on a wrong word, and a wrong encoding would not. A stream with irregular `out_ready` stalls catches results that change, are lost or are duplicated under back-pressure.

// File: rtl/divtmr_pkg.sv
package divtmr_pkg;
  typedef enum logic [1:0] {ENC_TRUE, ENC_INV, ENC_ROTL} enc_e;
  localparam int FN_W = 2;

  function automatic int chk_width(input int n);
    return (n % 2 == 1) ? 2 : 1;
  endfunction
endpackage

// File: rtl/divtmr_inreg.sv
module divtmr_inreg
  import divtmr_pkg::*;
#(
  parameter int   N   = 3,
  parameter enc_e ENC = ENC_TRUE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] din,
  input  logic [N-1:0] flt_en,
  input  logic [N-1:0] flt_val,
  output logic [N-1:0] q
);
  logic [N-1:0] enc_d;
  logic [N-1:0] stored;

  generate
    if (ENC == ENC_INV) begin : g_inv
      assign enc_d = ~din;
    end else if (ENC == ENC_ROTL) begin : g_rot
      for (genvar i = 0; i < N; i++) begin : g_bit
        assign enc_d[i] = din[(i + 1) % N];
      end
    end else begin : g_true
      assign enc_d = din;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stored <= '0;
    else if (load) stored <= enc_d;
  end

  assign q = (stored & ~flt_en) | (flt_val & flt_en);
endmodule

// File: rtl/divtmr_replica.sv
module divtmr_replica
  import divtmr_pkg::*;
#(
  parameter int   N   = 3,
  parameter enc_e ENC = ENC_TRUE,
  localparam int  CW  = chk_width(N),
  localparam int  W   = FN_W + CW
) (
  input  logic [N-1:0] q,
  output logic [W-1:0] word
);
  logic [N-1:0]    x;
  logic [FN_W-1:0] fn;
  logic [CW-1:0]   chk;

  generate
    if (ENC == ENC_INV) begin : g_inv
      assign x = ~q;
    end else if (ENC == ENC_ROTL) begin : g_rot
      for (genvar j = 0; j < N; j++) begin : g_bit
        assign x[j] = q[(j + N - 1) % N];
      end
    end else begin : g_true
      assign x = q;
    end
  endgenerate

  always_comb begin
    fn[0] = (x[0] & ~x[1]) | (x[1] & x[2]);
    fn[1] = (x[0] & ~x[1]) | (x[1] & ~x[2]);
  end

  generate
    if (N % 2 == 1) begin : g_odd
      always_comb begin
        chk[0] = 1'b0;
        for (int i = 0; i < N; i += 2) chk[0] = chk[0] ^ x[i];
        chk[1] = x[0];
      end
    end else begin : g_even
      always_comb begin
        chk[0] = 1'b0;
        for (int i = 1; i < N; i += 2) chk[0] = chk[0] ^ x[i];
      end
    end
  endgenerate

  generate
    if (ENC == ENC_INV) begin : g_oinv
      assign word = ~{chk, fn};
    end else begin : g_opass
      assign word = {chk, fn};
    end
  endgenerate
endmodule

// File: rtl/divtmr_voter.sv
module divtmr_voter #(
  parameter int W = 4
) (
  input  logic [W-1:0] w_a,
  input  logic [W-1:0] w_b_inv,
  input  logic [W-1:0] w_c,
  output logic [W-1:0] voted,
  output logic         err
);
  logic [W-1:0] w_b;
  logic         ab, ac, bc;

  assign w_b = ~w_b_inv;
  assign ab  = (w_a == w_b);
  assign ac  = (w_a == w_c);
  assign bc  = (w_b == w_c);

  always_comb begin
    if (ab || ac) voted = w_a;
    else if (bc)  voted = w_b;
    else          voted = w_a;
    err = !(ab || ac || bc);
  end
endmodule

// File: rtl/divtmr_top.sv
module divtmr_top
  import divtmr_pkg::*;
#(
  parameter int N_IN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N_IN-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FN_W-1:0]   out_data,
  output logic              out_err,
  input  logic [3*N_IN-1:0] flt_en,
  input  logic [3*N_IN-1:0] flt_val
);
  localparam int CW = chk_width(N_IN);
  localparam int W  = FN_W + CW;

  logic         vld;
  logic         load;
  logic [W-1:0] words [3];
  logic [W-1:0] voted;
  logic         verr;

  assign in_ready = !vld || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vld <= 1'b0;
    else if (load)      vld <= 1'b1;
    else if (out_ready) vld <= 1'b0;
  end

  generate
    for (genvar r = 0; r < 3; r++) begin : g_rep
      localparam enc_e E = (r == 0) ? ENC_TRUE : ((r == 1) ? ENC_INV : ENC_ROTL);
      logic [N_IN-1:0] q;

      divtmr_inreg #(.N(N_IN), .ENC(E)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .din    (in_data),
        .flt_en (flt_en[r*N_IN +: N_IN]),
        .flt_val(flt_val[r*N_IN +: N_IN]),
        .q      (q)
      );

      divtmr_replica #(.N(N_IN), .ENC(E)) u_rep (
        .q   (q),
        .word(words[r])
      );
    end
  endgenerate

  divtmr_voter #(.W(W)) u_vote (
    .w_a    (words[0]),
    .w_b_inv(words[1]),
    .w_c    (words[2]),
    .voted  (voted),
    .err    (verr)
  );

  assign out_valid = vld;
  assign out_data  = voted[FN_W-1:0];
  assign out_err   = vld && verr;
endmodule

// File: rtl/divtmr_chk.sv
module divtmr_chk #(
  parameter int N_IN = 3,
  parameter int FN_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FN_W-1:0]   out_data,
  input logic              out_err,
  input logic [3*N_IN-1:0] flt_en,
  input logic [3*N_IN-1:0] flt_val
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  // R3
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> (!($stable(flt_en) && $stable(flt_val)) || $stable(out_data)));
  // R3
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R2
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R2
  drain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (|flt_en));
  // R1
  idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_err);
endmodule

bind divtmr_top divtmr_chk #(.N_IN(N_IN), .FN_W(divtmr_pkg::FN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_err  (out_err),
  .flt_en   (flt_en),
  .flt_val  (flt_val)
);

// File: tb/divtmr_top_test.sv
module divtmr_top_test;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [1:0]   out_data;
  logic         out_err;
  logic [3*N-1:0] flt_en = '0;
  logic [3*N-1:0] flt_val = '0;

  int errors = 0;
  int checks = 0;
  logic [1:0] exp_q [$];

  always #2 clk = ~clk;

  divtmr_top #(.N_IN(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err), .flt_en(flt_en), .flt_val(flt_val)
  );

  function automatic logic [1:0] ref_fn(input logic [N-1:0] x);
    ref_fn[0] = (x[0] & ~x[1]) | (x[1] & x[2]);
    ref_fn[1] = (x[0] & ~x[1]) | (x[1] & ~x[2]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_expected(input logic [N-1:0] x);
    exp_q.push_back(ref_fn(x));
  endtask

  task automatic load_op(input logic [N-1:0] x);
    @(negedge clk);
    flt_en = '0; flt_val = '0;
    in_valid = 1'b1; in_data = x; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic set_fault(input int r, input int i, input bit v);
    flt_en[r*N+i]  = 1'b1;
    flt_val[r*N+i] = v;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] held;
    bit         stalled;
    int         sent;
    int         got;
    int         cyc;
    int         errcnt;

    // R1: reset state
    #7;
    check(out_valid === 1'b0, "R1 valid in reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 ready in reset", in_ready, 1);
    check(out_err === 1'b0, "R1 err in reset", out_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1 valid after reset", out_valid, 0);

    // R2, R3, R4: fault-free stream with stalls (scoreboard)
    sent = 0; got = 0; stalled = 0; held = '0; cyc = 0;
    while (got < 16) begin
      @(negedge clk);
      in_valid  = (sent < 16) && (cyc % 3 != 2);
      in_data   = N'(sent % 8);
      out_ready = (cyc % 4 != 1) && (cyc % 7 != 3);
      #1;
      if (stalled) begin
        check(out_valid === 1'b1 && out_data === held, "R3 held under stall", out_data, held);
      end
      if (out_valid && !out_ready) begin
        check(in_ready === 1'b0, "R3 ready low when stalled", in_ready, 0);
        stalled = 1; held = out_data;
      end else stalled = 0;
      if (out_valid && out_ready) begin
        check(exp_q.size() > 0 && out_data === exp_q[0], "R2 result", out_data,
              exp_q.size() > 0 ? exp_q[0] : 0);
        check(out_err === 1'b0, "R4 no error without fault", out_err, 0);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        got++;
      end
      if (in_valid && in_ready) begin
        push_expected(in_data);
        sent++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;

    // R2: stated example operand
    load_op(3'b001);
    #1;
    check(out_data === 2'b11 && out_err === 1'b0, "R2 x1=1 example", out_data, 3);

    // R8: all three registers, position 0 stuck at 1, operand x3=1
    load_op(3'b100);
    @(negedge clk);
    set_fault(0, 0, 1); set_fault(1, 0, 1); set_fault(2, 0, 1);
    #1;
    check(out_err === 1'b1, "R8 triple stuck flags error", out_err, 1);

    // R9: rotation direction
    load_op(3'b000);
    @(negedge clk);
    set_fault(0, 0, 1); set_fault(2, N-1, 1);
    #1;
    check(out_data === 2'b11 && out_err === 1'b0, "R9 rotated register position", out_data, 3);
    // R9: complemented register
    @(negedge clk);
    flt_en = '0; flt_val = '0;
    set_fault(0, 0, 1); set_fault(1, 0, 0);
    #1;
    check(out_data === 2'b11 && out_err === 1'b0, "R9 complemented register", out_data, 3);
    // R5: force is immediate and releases without reload
    @(negedge clk);
    flt_en = '0; flt_val = '0;
    #1;
    check(out_data === 2'b00 && out_err === 1'b0, "R5 release of force", out_data, 0);

    // R6, R7: exhaustive sweeps
    errcnt = 0;
    for (int x = 0; x < 8; x++) begin
      load_op(N'(x));
      for (int r = 0; r < 3; r++) begin
        for (int i = 0; i < N; i++) begin
          for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            flt_en = '0; flt_val = '0;
            set_fault(r, i, v[0]);
            #1;
            check(out_data === ref_fn(N'(x)) && out_err === 1'b0, "R6 single stuck masked",
                  {out_err, out_data}, ref_fn(N'(x)));
          end
        end
      end
      for (int m = 3; m < 8; m++) begin
        if (m == 4) continue;
        for (int i = 0; i < N; i++) begin
          for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            flt_en = '0; flt_val = '0;
            for (int r = 0; r < 3; r++) if (m[r]) set_fault(r, i, v[0]);
            #1;
            if (out_err) errcnt++;
            check(out_err === 1'b1 || out_data === ref_fn(N'(x)), "R7 same-position stuck",
                  out_data, ref_fn(N'(x)));
          end
        end
      end
    end
    check(errcnt > 0, "R7 some faults flagged", errcnt, 1);
    @(negedge clk);
    flt_en = '0; flt_val = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule